// File: doc/BRIEF.md
# Clock and Reset Control Register File

This block is the software-visible register file of a microcontroller clock and reset controller. A simple 32-bit register bus carries a byte address inside a 1 KiB window, a select, a write enable and write data. The block returns registered read data and a one-cycle error flag. The file holds several groups of registers:

- the oscillator/PLL control word
- the main PLL configuration
- the clock configuration
- the low-speed oscillator control/status word
- one enable word and one low-power enable word for each of five peripheral bus groups (three high-speed, two low-speed)
- stub words (interrupt, peripheral reset, backup domain, spread spectrum, audio PLL) that only return their reset value

No real oscillator or PLL sits behind the file. Each ready flag simply follows its enable bit in the same write. The decoded PLL divider, multiplier and post-divider codes, the PLL source, the system clock select and the AHB prescaler code are driven out continuously to a downstream clock-rate calculator. A single-cycle change pulse tells that calculator to recompute whenever a clock-affecting register is written.

Top module: `clkctl_regfile`

## Requirements
- R1: After reset the mapped words read as follows, with every other mapped word reading 0:
  - 0x00 = 0x00000083, 0x04 = 0x24003010
  - 0x30 = 0x00100000
  - 0x50 = 0x7E6791FF, 0x54 = 0x000000F1, 0x58 = 0x00000001, 0x60 = 0x36FEC9FF, 0x64 = 0x00075F33
  - 0x74 = 0x0E000000, 0x84 = 0x20003000

  Read data appears on the cycle after the read request and holds until the next read.
- R2: A write to 0x00 copies each on bit into its ready bit: bit 0 to bit 1, bit 16 to bit 17, bit 24 to bit 25 and bit 26 to bit 27. The bits outside 0–1 and 16–27 keep their old value.
- R3: Bit 18 (external bypass) of word 0x00 becomes 1 only if the same write has bit 16 and bit 18 both set; otherwise it becomes 0.
- R4: A write to 0x04 updates only bits [5:0] (M), [14:6] (N), [17:16] (P code) and [22] (source). These fields drive pll_div_m, pll_mul_n, pll_div_p and pll_src_ext.
- R5: A write to 0x08 updates only bits [1:0] (source select) and [7:4] (AHB code), and sets bits [3:2] equal to the written bits [1:0]. sys_src and ahb_code follow bits [1:0] and [7:4].
- R6: A write to 0x74 takes only bit 0 and sets bit 1 equal to it. All other bits keep their value.
- R7: Writes to 0x0C, 0x10, 0x14, 0x18, 0x20, 0x24, 0x70, 0x80 and 0x84 change nothing. These words keep reading their reset value.
- R8: The five enable words (0x30, 0x34, 0x38, 0x40, 0x44) and the five low-power enable words (0x50, 0x54, 0x58, 0x60, 0x64) store and read back the full 32-bit written value.
- R9: An access to an offset outside the map reads 0 and discards any write. It raises bus_err for exactly the following cycle. An access to a mapped offset leaves bus_err low.
- R10: cfg_changed pulses for one cycle, on the cycle after a write to 0x00, 0x04, 0x08 or 0x74, and is low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access request this cycle |
| bus_wen | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 10 | Byte address in the window (bits [1:0] ignored) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_err | output | 1 | One-cycle unmapped-access flag |
| pll_div_m | output | 6 | PLL input divider field |
| pll_mul_n | output | 9 | PLL multiplier field |
| pll_div_p | output | 2 | PLL output divider code |
| pll_src_ext | output | 1 | PLL source: 1 = external oscillator |
| sys_src | output | 2 | System clock source select |
| ahb_code | output | 4 | AHB prescaler code |
| cfg_changed | output | 1 | Clock-configuration change pulse |

## Verification
The bench targets bypass writes with the external oscillator disabled. A design that stores the raw bit would read bypass set without ready. It writes all-ones to the PLL, clock and status words, which catches a design that lets reserved or divider-Q bits through, or that fails to mirror the switch status. It hits stub and peripheral-reset offsets with all-ones, which exposes a design that stores stub writes. It probes holes in the map (0x1C, 0x28, 0x2C) as well as offsets past the end, where a loose decoder would alias a real register or drop the error pulse. Writes to enable words must not pulse the change strobe, and a design that pulses on any write is caught there.

// File: rtl/clkctl_pkg.sv
package clkctl_pkg;

    typedef logic [31:0] word_t;

    typedef enum logic [3:0] {
        RS_NONE, RS_OSC, RS_PLL, RS_CLK, RS_IRQ, RS_PRST,
        RS_PEN, RS_PLP, RS_BKUP, RS_STAT, RS_SPRD, RS_APLL
    } rsel_e;

    // word indices (byte offset / 4)
    localparam int W_OSC      = 0;
    localparam int W_PLL      = 1;
    localparam int W_CLK      = 2;
    localparam int W_IRQ      = 3;
    localparam int W_PRST     = 4;
    localparam int W_PEN      = 12;
    localparam int W_PLP      = 20;
    localparam int W_BKUP     = 28;
    localparam int W_STAT     = 29;
    localparam int W_SPRD     = 32;
    localparam int W_APLL     = 33;
    localparam int W_APB_SKIP = 4;

    // control word bit positions
    localparam int B_HSI_ON   = 0;
    localparam int B_HSI_RDY  = 1;
    localparam int B_HSE_ON   = 16;
    localparam int B_HSE_RDY  = 17;
    localparam int B_HSE_BYP  = 18;
    localparam int B_PLL_ON   = 24;
    localparam int B_PLL_RDY  = 25;
    localparam int B_APLL_ON  = 26;
    localparam int B_APLL_RDY = 27;

    localparam word_t INIT_OSC  = 32'h0000_0083;
    localparam word_t INIT_PLL  = 32'h2400_3010;
    localparam word_t INIT_STAT = 32'h0E00_0000;
    localparam word_t INIT_APLL = 32'h2000_3000;
    localparam word_t PLL_WMASK = 32'h0043_7FFF;

    function automatic int bank_word(int b, int n_ahb);
        return (b < n_ahb) ? b : (W_APB_SKIP + b - n_ahb);
    endfunction

    function automatic word_t pen_init(int b);
        return (b == 0) ? 32'h0010_0000 : 32'h0;
    endfunction

    function automatic word_t plp_init(int b);
        case (b)
            0:       return 32'h7E67_91FF;
            1:       return 32'h0000_00F1;
            2:       return 32'h0000_0001;
            3:       return 32'h36FE_C9FF;
            4:       return 32'h0007_5F33;
            default: return 32'h0;
        endcase
    endfunction

endpackage

// File: rtl/clkctl_addr_dec.sv
module clkctl_addr_dec
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int N_AHB  = 3,
    parameter int N_APB  = 2
) (
    input  logic [ADDR_W-1:0]                 addr,
    output rsel_e                             sel,
    output logic [$clog2(N_AHB+N_APB)-1:0]    bank
);
    localparam int NB    = N_AHB + N_APB;
    localparam int IDX_W = $clog2(NB);
    localparam int WI_W  = ADDR_W - 2;

    logic [WI_W-1:0] widx;
    logic [NB-1:0]   hit_rst, hit_en, hit_lp;

    assign widx = addr[ADDR_W-1:2];

    for (genvar b = 0; b < NB; b++) begin : g_bank
        localparam int OFF = bank_word(b, N_AHB);
        assign hit_rst[b] = (widx == WI_W'(W_PRST + OFF));
        assign hit_en[b]  = (widx == WI_W'(W_PEN + OFF));
        assign hit_lp[b]  = (widx == WI_W'(W_PLP + OFF));
    end

    always_comb begin
        sel  = RS_NONE;
        bank = '0;
        if      (widx == WI_W'(W_OSC))  sel = RS_OSC;
        else if (widx == WI_W'(W_PLL))  sel = RS_PLL;
        else if (widx == WI_W'(W_CLK))  sel = RS_CLK;
        else if (widx == WI_W'(W_IRQ))  sel = RS_IRQ;
        else if (widx == WI_W'(W_BKUP)) sel = RS_BKUP;
        else if (widx == WI_W'(W_STAT)) sel = RS_STAT;
        else if (widx == WI_W'(W_SPRD)) sel = RS_SPRD;
        else if (widx == WI_W'(W_APLL)) sel = RS_APLL;
        for (int b = 0; b < NB; b++) begin
            if (hit_rst[b]) sel = RS_PRST;
            if (hit_en[b]) begin
                sel  = RS_PEN;
                bank = IDX_W'(b);
            end
            if (hit_lp[b]) begin
                sel  = RS_PLP;
                bank = IDX_W'(b);
            end
        end
    end
endmodule

// File: rtl/clkctl_wmerge.sv
module clkctl_wmerge
    import clkctl_pkg::*;
(
    input  rsel_e sel,
    input  word_t wdata,
    input  word_t osc_q,
    input  word_t pll_q,
    input  word_t clk_q,
    input  word_t stat_q,
    output word_t osc_n,
    output word_t pll_n,
    output word_t clk_n,
    output word_t stat_n,
    output logic  clk_affecting
);
    always_comb begin
        osc_n              = osc_q;
        osc_n[B_HSI_ON]    = wdata[B_HSI_ON];
        osc_n[B_HSI_RDY]   = wdata[B_HSI_ON];
        osc_n[B_HSE_ON]    = wdata[B_HSE_ON];
        osc_n[B_HSE_RDY]   = wdata[B_HSE_ON];
        osc_n[B_HSE_BYP]   = wdata[B_HSE_ON] & wdata[B_HSE_BYP];
        osc_n[B_PLL_ON]    = wdata[B_PLL_ON];
        osc_n[B_PLL_RDY]   = wdata[B_PLL_ON];
        osc_n[B_APLL_ON]   = wdata[B_APLL_ON];
        osc_n[B_APLL_RDY]  = wdata[B_APLL_ON];

        pll_n = (pll_q & ~PLL_WMASK) | (wdata & PLL_WMASK);

        clk_n      = clk_q;
        clk_n[1:0] = wdata[1:0];
        clk_n[3:2] = wdata[1:0];
        clk_n[7:4] = wdata[7:4];

        stat_n    = stat_q;
        stat_n[0] = wdata[0];
        stat_n[1] = wdata[0];

        clk_affecting = (sel == RS_OSC) || (sel == RS_PLL) ||
                        (sel == RS_CLK) || (sel == RS_STAT);
    end
endmodule

// File: rtl/clkctl_rd_mux.sv
module clkctl_rd_mux
    import clkctl_pkg::*;
#(
    parameter int NB    = 5,
    parameter int IDX_W = 3
) (
    input  rsel_e            sel,
    input  logic [IDX_W-1:0] bank,
    input  word_t            osc,
    input  word_t            pll,
    input  word_t            clk,
    input  word_t            stat,
    input  word_t            pen [NB],
    input  word_t            plp [NB],
    output word_t            rdata
);
    always_comb begin
        rdata = '0;
        case (sel)
            RS_OSC:  rdata = osc;
            RS_PLL:  rdata = pll;
            RS_CLK:  rdata = clk;
            RS_STAT: rdata = stat;
            RS_APLL: rdata = INIT_APLL;
            RS_PEN: begin
                for (int b = 0; b < NB; b++)
                    if (bank == IDX_W'(b)) rdata = pen[b];
            end
            RS_PLP: begin
                for (int b = 0; b < NB; b++)
                    if (bank == IDX_W'(b)) rdata = plp[b];
            end
            default: rdata = '0;
        endcase
    end
endmodule

// File: rtl/clkctl_regfile.sv
module clkctl_regfile
    import clkctl_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int N_AHB  = 3,
    parameter int N_APB  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wen,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              bus_err,
    output logic [5:0]        pll_div_m,
    output logic [8:0]        pll_mul_n,
    output logic [1:0]        pll_div_p,
    output logic              pll_src_ext,
    output logic [1:0]        sys_src,
    output logic [3:0]        ahb_code,
    output logic              cfg_changed
);
    localparam int NB    = N_AHB + N_APB;
    localparam int IDX_W = $clog2(NB);

    typedef struct {
        word_t osc;
        word_t pll;
        word_t clk;
        word_t stat;
        word_t pen [NB];
        word_t plp [NB];
        word_t rdata;
        logic  err;
        logic  chg;
    } state_t;

    state_t s_d, s_q;

    rsel_e            sel;
    logic [IDX_W-1:0] bank;
    word_t            rd_val;
    word_t            osc_n, pll_n, clk_n, stat_n;
    logic             clk_affecting;

    clkctl_addr_dec #(.ADDR_W(ADDR_W), .N_AHB(N_AHB), .N_APB(N_APB)) u_dec (
        .addr (bus_addr),
        .sel  (sel),
        .bank (bank)
    );

    clkctl_wmerge u_merge (
        .sel           (sel),
        .wdata         (bus_wdata),
        .osc_q         (s_q.osc),
        .pll_q         (s_q.pll),
        .clk_q         (s_q.clk),
        .stat_q        (s_q.stat),
        .osc_n         (osc_n),
        .pll_n         (pll_n),
        .clk_n         (clk_n),
        .stat_n        (stat_n),
        .clk_affecting (clk_affecting)
    );

    clkctl_rd_mux #(.NB(NB), .IDX_W(IDX_W)) u_rd (
        .sel   (sel),
        .bank  (bank),
        .osc   (s_q.osc),
        .pll   (s_q.pll),
        .clk   (s_q.clk),
        .stat  (s_q.stat),
        .pen   (s_q.pen),
        .plp   (s_q.plp),
        .rdata (rd_val)
    );

    always_comb begin
        s_d     = s_q;
        s_d.err = 1'b0;
        s_d.chg = 1'b0;
        if (bus_sel) begin
            if (!bus_wen)
                s_d.rdata = rd_val;
            if (sel == RS_NONE) begin
                s_d.err = 1'b1;
            end else if (bus_wen) begin
                case (sel)
                    RS_OSC:  s_d.osc  = osc_n;
                    RS_PLL:  s_d.pll  = pll_n;
                    RS_CLK:  s_d.clk  = clk_n;
                    RS_STAT: s_d.stat = stat_n;
                    default: ;
                endcase
                for (int b = 0; b < NB; b++) begin
                    if (sel == RS_PEN && bank == IDX_W'(b)) s_d.pen[b] = bus_wdata;
                    if (sel == RS_PLP && bank == IDX_W'(b)) s_d.plp[b] = bus_wdata;
                end
                s_d.chg = clk_affecting;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.osc   <= INIT_OSC;
            s_q.pll   <= INIT_PLL;
            s_q.clk   <= '0;
            s_q.stat  <= INIT_STAT;
            for (int b = 0; b < NB; b++) begin
                s_q.pen[b] <= pen_init(b);
                s_q.plp[b] <= plp_init(b);
            end
            s_q.rdata <= '0;
            s_q.err   <= 1'b0;
            s_q.chg   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign bus_rdata   = s_q.rdata;
    assign bus_err     = s_q.err;
    assign cfg_changed = s_q.chg;
    assign pll_div_m   = s_q.pll[5:0];
    assign pll_mul_n   = s_q.pll[14:6];
    assign pll_div_p   = s_q.pll[17:16];
    assign pll_src_ext = s_q.pll[22];
    assign sys_src     = s_q.clk[1:0];
    assign ahb_code    = s_q.clk[7:4];
endmodule

// File: rtl/clkctl_regfile_chk.sv
module clkctl_regfile_chk #(
    parameter int ADDR_W = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wen,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [31:0]       bus_rdata,
    input logic              bus_err,
    input logic [5:0]        pll_div_m,
    input logic [8:0]        pll_mul_n,
    input logic [1:0]        pll_div_p,
    input logic              pll_src_ext,
    input logic [1:0]        sys_src,
    input logic [3:0]        ahb_code,
    input logic              cfg_changed
);
    logic [ADDR_W-3:0] widx;
    logic              rd_req;
    assign widx   = bus_addr[ADDR_W-1:2];
    assign rd_req = bus_sel && !bus_wen;

    // R2
    ready_mirror_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && widx == 0) |=> (bus_rdata[1] == bus_rdata[0] &&
            bus_rdata[17] == bus_rdata[16] && bus_rdata[25] == bus_rdata[24] &&
            bus_rdata[27] == bus_rdata[26]));

    // R3
    bypass_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && widx == 0) |=> (!bus_rdata[18] || bus_rdata[17]));

    // R5
    switch_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && widx == 2) |=> (bus_rdata[3:2] == bus_rdata[1:0] &&
            sys_src == bus_rdata[1:0] && ahb_code == bus_rdata[7:4]));

    // R4
    fields_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wen) |=> ($stable(pll_div_m) && $stable(pll_mul_n) &&
            $stable(pll_div_p) && $stable(pll_src_ext) && $stable(sys_src) &&
            $stable(ahb_code)));

    // R9
    unmapped_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && widx > 33) |=> bus_err);

    // R9
    unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && widx > 33) |=> (bus_rdata == 32'h0));

    // R10
    no_write_no_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_sel && bus_wen) |=> !cfg_changed);
endmodule

bind clkctl_regfile clkctl_regfile_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wen     (bus_wen),
    .bus_addr    (bus_addr),
    .bus_rdata   (bus_rdata),
    .bus_err     (bus_err),
    .pll_div_m   (pll_div_m),
    .pll_mul_n   (pll_mul_n),
    .pll_div_p   (pll_div_p),
    .pll_src_ext (pll_src_ext),
    .sys_src     (sys_src),
    .ahb_code    (ahb_code),
    .cfg_changed (cfg_changed)
);

// File: tb/test_clkctl_regfile.sv
module test_clkctl_regfile;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wen = 1'b0;
    logic [9:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_err;
    logic [5:0]  pll_div_m;
    logic [8:0]  pll_mul_n;
    logic [1:0]  pll_div_p;
    logic        pll_src_ext;
    logic [1:0]  sys_src;
    logic [3:0]  ahb_code;
    logic        cfg_changed;

    int    checks = 0;
    int    errors = 0;
    string cur_req = "R1";

    logic [31:0] m_osc, m_pll, m_clk, m_stat;
    logic [31:0] m_pen [5];
    logic [31:0] m_plp [5];
    logic [31:0] exp_rdata;
    logic        exp_err, exp_chg;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkctl_regfile i_clkctl_regfile (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wen(bus_wen),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .bus_err(bus_err), .pll_div_m(pll_div_m), .pll_mul_n(pll_mul_n),
        .pll_div_p(pll_div_p), .pll_src_ext(pll_src_ext), .sys_src(sys_src),
        .ahb_code(ahb_code), .cfg_changed(cfg_changed)
    );

    function automatic int bank_of(int a, int base);
        case (a - base)
            'h00: return 0;
            'h04: return 1;
            'h08: return 2;
            'h10: return 3;
            'h14: return 4;
            default: return -1;
        endcase
    endfunction

    function automatic logic [31:0] mread(int a);
        int b;
        case (a)
            'h00: return m_osc;
            'h04: return m_pll;
            'h08: return m_clk;
            'h74: return m_stat;
            'h84: return 32'h2000_3000;
            default: ;
        endcase
        b = bank_of(a, 'h30);
        if (b >= 0) return m_pen[b];
        b = bank_of(a, 'h50);
        if (b >= 0) return m_plp[b];
        return 32'h0;
    endfunction

    function automatic logic mapped(int a);
        if (a == 'h00 || a == 'h04 || a == 'h08 || a == 'h0C) return 1'b1;
        if (a == 'h70 || a == 'h74 || a == 'h80 || a == 'h84) return 1'b1;
        if (bank_of(a, 'h10) >= 0 || bank_of(a, 'h30) >= 0 || bank_of(a, 'h50) >= 0)
            return 1'b1;
        return 1'b0;
    endfunction

    task automatic mwrite(int a, logic [31:0] w);
        int b;
        case (a)
            'h00: begin
                m_osc[1:0]   = {w[0], w[0]};
                m_osc[16]    = w[16];
                m_osc[17]    = w[16];
                m_osc[18]    = w[16] & w[18];
                m_osc[24]    = w[24];
                m_osc[25]    = w[24];
                m_osc[26]    = w[26];
                m_osc[27]    = w[26];
            end
            'h04: begin
                m_pll[5:0]   = w[5:0];
                m_pll[14:6]  = w[14:6];
                m_pll[17:16] = w[17:16];
                m_pll[22]    = w[22];
            end
            'h08: begin
                m_clk[1:0] = w[1:0];
                m_clk[3:2] = w[1:0];
                m_clk[7:4] = w[7:4];
            end
            'h74: m_stat[1:0] = {w[0], w[0]};
            default: begin
                b = bank_of(a, 'h30);
                if (b >= 0) m_pen[b] = w;
                b = bank_of(a, 'h50);
                if (b >= 0) m_plp[b] = w;
            end
        endcase
    endtask

    task automatic model_reset();
        m_osc  = 32'h0000_0083;
        m_pll  = 32'h2400_3010;
        m_clk  = 32'h0;
        m_stat = 32'h0E00_0000;
        m_pen  = '{32'h0010_0000, 32'h0, 32'h0, 32'h0, 32'h0};
        m_plp  = '{32'h7E67_91FF, 32'h0000_00F1, 32'h0000_0001,
                   32'h36FE_C9FF, 32'h0007_5F33};
        exp_rdata = 32'h0;
        exp_err   = 1'b0;
        exp_chg   = 1'b0;
    endtask

    task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s %s got=%h exp=%h t=%0t", cur_req, what, got, exp, $time);
        end
    endtask

    task automatic step();
        int a;
        @(posedge clk);
        a = int'(bus_addr);
        if (!rst_n) begin
            model_reset();
        end else begin
            exp_err = bus_sel && !mapped(a);
            exp_chg = bus_sel && bus_wen &&
                      (a == 'h00 || a == 'h04 || a == 'h08 || a == 'h74);
            if (bus_sel && !bus_wen) exp_rdata = mread(a);
            if (bus_sel && bus_wen && mapped(a)) mwrite(a, bus_wdata);
        end
        @(negedge clk);
        chk("rdata", bus_rdata, exp_rdata);
        chk("err", {31'h0, bus_err}, {31'h0, exp_err});
        chk("chg", {31'h0, cfg_changed}, {31'h0, exp_chg});
        chk("fields", {8'h0, pll_div_m, pll_mul_n, pll_div_p, pll_src_ext, sys_src, ahb_code},
            {8'h0, m_pll[5:0], m_pll[14:6], m_pll[17:16], m_pll[22], m_clk[1:0], m_clk[7:4]});
    endtask

    task automatic wr(int a, logic [31:0] w);
        bus_sel = 1'b1; bus_wen = 1'b1; bus_addr = 10'(a); bus_wdata = w;
        step();
        bus_sel = 1'b0; bus_wen = 1'b0;
    endtask

    task automatic rd(int a);
        bus_sel = 1'b1; bus_wen = 1'b0; bus_addr = 10'(a); bus_wdata = 32'hDEAD_BEEF;
        step();
        bus_sel = 1'b0;
    endtask

    task automatic idle();
        bus_sel = 1'b0; bus_wen = 1'b0;
        step();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int maplist [23] = '{'h00, 'h04, 'h08, 'h0C, 'h10, 'h14, 'h18, 'h20, 'h24,
                             'h30, 'h34, 'h38, 'h40, 'h44, 'h50, 'h54, 'h58,
                             'h60, 'h64, 'h70, 'h74, 'h80, 'h84};
        int stubs [9] = '{'h0C, 'h10, 'h14, 'h18, 'h20, 'h24, 'h70, 'h80, 'h84};
        int banks [10] = '{'h30, 'h34, 'h38, 'h40, 'h44, 'h50, 'h54, 'h58, 'h60, 'h64};
        model_reset();
        @(negedge clk);
        step();
        step();
        rst_n = 1'b1;
        idle();

        cur_req = "R1";
        foreach (maplist[i]) rd(maplist[i]);
        idle();
        idle();

        cur_req = "R2";
        wr('h00, 32'h0501_0001); rd('h00);
        wr('h00, 32'h0000_0000); rd('h00);
        wr('h00, 32'hFAFE_FFFE); rd('h00);

        cur_req = "R3";
        wr('h00, 32'h0004_0000); rd('h00);
        wr('h00, 32'h0005_0000); rd('h00);
        wr('h00, 32'h0001_0000); rd('h00);

        cur_req = "R4";
        wr('h04, 32'hFFFF_FFFF); rd('h04);
        wr('h04, 32'h0040_0000 | (32'd336 << 6) | 32'd8 | (32'd1 << 16)); rd('h04);
        wr('h04, 32'h0000_0000); rd('h04);

        cur_req = "R5";
        wr('h08, 32'hFFFF_FFF2); rd('h08);
        wr('h08, 32'h0000_0081); rd('h08);

        cur_req = "R6";
        wr('h74, 32'hFFFF_FFFF); rd('h74);
        wr('h74, 32'hFFFF_FFFE); rd('h74);

        cur_req = "R7";
        foreach (stubs[i]) wr(stubs[i], 32'hFFFF_FFFF);
        foreach (stubs[i]) rd(stubs[i]);

        cur_req = "R8";
        foreach (banks[i]) wr(banks[i], 32'hA5A5_0000 ^ (32'h1111_1111 * 32'(i)));
        foreach (banks[i]) rd(banks[i]);
        wr('h44, 32'hFFFF_FFFF); rd('h44);

        cur_req = "R9";
        wr('h2C, 32'hFFFF_FFFF); rd('h2C);
        rd('h1C); rd('h28); rd('h88); rd('h3FC);
        wr('h3FC, 32'h1234_5678); idle();
        foreach (maplist[i]) rd(maplist[i]);

        cur_req = "R10";
        wr('h30, 32'h0000_0001); idle();
        wr('h08, 32'h0000_0002); idle();
        wr('h84, 32'h0); wr('h74, 32'h1); wr('h04, 32'h2400_3010); idle();

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule